// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block makes the timing signals for a two-channel audio serial port from one core clock. As clock source (host role) it drives three pins: a master clock for an external codec, a serial bit clock, and a word-select clock that tells left samples from right samples. As clock follower (client role) it drives none of these pins. It takes the bit clock and word select from outside, brings them into the core clock domain and hands them to the rest of the port. In both roles it gives the data shifter two one-cycle strobes. One marks each change of channel and the other marks the start of each stereo frame.

Two divider fields set the timing. The rate field sets how many core cycles one stereo sample takes. The master-clock divider field sets the master clock period. A 3-bit data-length code and a compact-slot flag select the slot length, which is the number of bit-clock periods per channel. The master clock output can be switched off. The rate field then gives the bit clock period directly. The configuration is captured only while the block is idle, and every enable starts the clocks from the same phase.

Top module: `audclk_gen`

## Requirements
- R1: In host role (`host_mode`=1 when captured), `pin_oe` is 1 and `sck_int`/`ws_int` equal `sck_o`/`ws_o`. In client role, `pin_oe` is 0 and `mck_o`, `sck_o` and `ws_o` stay 0.
- R2: In client role, `sck_int` and `ws_int` repeat `sck_in` and `ws_in` two core cycles later. While enabled, `slot_stb` is high for the one cycle in which `ws_int` has just changed, and `frame_stb` is high for the one cycle in which it has just fallen.
- R3: Slot length S comes from `dlen` and `compact24`: code 0 gives 32; codes 1, 2 and 3 give 32 (flag 0) or 24 (flag 1); codes 4 and 5 give 16; codes 6 and 7 give 8. The flag has no effect on codes 0 and 4 to 7.
- R4: With `mclk_on`=1, the master clock period is `mclk_div`+1 core cycles and the bit clock period is 16·(`fs_mult`+1)/S core cycles. One stereo sample therefore takes 32·(`fs_mult`+1) core cycles.
- R5: With `mclk_on`=0, `mck_o` stays 0 and the bit clock period is `fs_mult`+1 core cycles.
- R6: A generated clock with a period of P core cycles is high for ceil(P/2) cycles and then low for floor(P/2) cycles.
- R7: In host role, `ws_o` is 0 for the left slot and 1 for the right slot. It changes only in the cycle in which `sck_o` falls, once every S falling edges. The first change, to 1, comes with the S-th falling edge after enable.
- R8: In host role, while enabled, `cfg_err` is 1 in any of these cases: the bit period is not a whole number of core cycles, the bit period is below 2, or, with the master clock on, the master period is below 2 or does not divide the bit period. While `cfg_err` is 1, all clock outputs stay 0. In client role `cfg_err` stays 0.
- R9: The configuration inputs are captured only while `enable` is 0. A change while enabled has no effect on any output.
- R10: When `enable` is first seen high at a clock edge, the generated clocks are low after that edge and high after the next edge, and `ws_o` starts at 0.
- R11: In host role, `slot_stb` is 1 for exactly the cycles in which `ws_o` has just changed, and `frame_stb` for those in which it has just fallen.
- R12: Two core cycles after reset or after `enable` falls, `mck_o`, `sck_o`, `ws_o` and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the block; configuration is captured while low |
| host_mode | input | 1 | 1 selects host role, 0 selects client role |
| mclk_on | input | 1 | Master clock output enable |
| compact24 | input | 1 | 24-cycle slot for codes 1 to 3 |
| dlen | input | 3 | Data-length code |
| fs_mult | input | FS_W | Rate field |
| mclk_div | input | DIV_W | Master clock divider field |
| sck_in | input | 1 | External bit clock (client role) |
| ws_in | input | 1 | External word select (client role) |
| mck_o | output | 1 | Master clock pin |
| sck_o | output | 1 | Bit clock pin |
| ws_o | output | 1 | Word-select pin |
| pin_oe | output | 1 | Drive enable for the three clock pins |
| sck_int | output | 1 | Bit clock to the port |
| ws_int | output | 1 | Word select to the port |
| frame_stb | output | 1 | One-cycle frame boundary strobe |
| slot_stb | output | 1 | One-cycle slot boundary strobe |
| cfg_err | output | 1 | Inconsistent divider setting |

## Verification
The bench sweeps every data-length code with both compact-flag values and with the master clock on and off. Rate values include odd ones that leave a fraction on a 32-cycle slot or a 24-cycle slot. Divider values include zero and values that do not divide the bit period. Each enabled cycle is compared with a waveform computed from the formulas. A wrong slot table moves the word-select edges. An off-by-one in a divider stretches every period. Wrong duty rounding shifts the falling edges and, with them, the strobes.

Settings that should be rejected must keep all pins silent; a missed check would let a fractional ratio toggle the clocks. Scrambling the inputs in the middle of a run catches a capture register that is open while enabled. The client pass-through is checked for its two-cycle latency and for strobes that follow the external word select.

// File: rtl/audclk_pkg.sv
// Package audclk_pkg: slot classes and the data-length decode shared by the
// audio clock generator. Assumes a 3-bit data-length code.
package audclk_pkg;

    localparam int SLOT_W = 6;

    typedef enum logic [1:0] {
        SLOT_8  = 2'd0,
        SLOT_16 = 2'd1,
        SLOT_24 = 2'd2,
        SLOT_32 = 2'd3
    } slot_e;

    // Map the data-length code and compact flag to a slot class.
    function automatic slot_e slot_class(input logic [2:0] code, input logic compact);
        slot_e cls;
        unique case (code)
            3'd0:                cls = SLOT_32;
            3'd1, 3'd2, 3'd3:    cls = compact ? SLOT_24 : SLOT_32;
            3'd4, 3'd5:          cls = SLOT_16;
            default:             cls = SLOT_8;
        endcase
        return cls;
    endfunction

    // Number of bit-clock periods in one slot of the given class.
    function automatic logic [SLOT_W-1:0] slot_bits(input slot_e cls);
        logic [SLOT_W-1:0] n;
        unique case (cls)
            SLOT_8:  n = SLOT_W'(8);
            SLOT_16: n = SLOT_W'(16);
            SLOT_24: n = SLOT_W'(24);
            default: n = SLOT_W'(32);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/audclk_cfg.sv
// Module audclk_cfg: captures the configuration while the block is idle and
// derives the bit and master clock periods plus the error flag.
// Assumes: the capture is open only while enable and run are both low, so the
// derived periods stay constant while the dividers run.
module audclk_cfg
    import audclk_pkg::*;
#(
    parameter int FS_W  = 6,
    parameter int DIV_W = 6,
    parameter int PW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                run,
    input  logic                host_mode,
    input  logic                mclk_on,
    input  logic                compact24,
    input  logic [2:0]          dlen,
    input  logic [FS_W-1:0]     fs_mult,
    input  logic [DIV_W-1:0]    mclk_div,
    output logic                host_q,
    output logic                mclk_q,
    output logic [SLOT_W-1:0]   slot_len,
    output logic [PW-1:0]       bit_period,
    output logic [PW-1:0]       mclk_period,
    output logic                bad_cfg
);

    slot_e             cls_q;
    logic [FS_W-1:0]   fs_q;
    logic [DIV_W-1:0]  div_q;
    logic [PW-1:0]     fsp1;
    logic [PW-1:0]     dbl;
    logic              frac;

    // Capture the configuration fields only while the block is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_q <= 1'b0;
            mclk_q <= 1'b0;
            cls_q  <= SLOT_32;
            fs_q   <= '0;
            div_q  <= '0;
        end else if (!enable && !run) begin
            host_q <= host_mode;
            mclk_q <= mclk_on;
            cls_q  <= slot_class(dlen, compact24);
            fs_q   <= fs_mult;
            div_q  <= mclk_div;
        end
    end

    assign slot_len = slot_bits(cls_q);

    // Derive the bit clock period in core cycles and flag a fractional result.
    always_comb begin
        fsp1 = PW'(fs_q) + PW'(1);
        dbl  = fsp1 << 1;
        frac = 1'b0;
        bit_period = fsp1;
        if (mclk_q) begin
            unique case (cls_q)
                SLOT_32: begin
                    bit_period = fsp1 >> 1;
                    frac       = fsp1[0];
                end
                SLOT_24: begin
                    bit_period = dbl / PW'(3);
                    frac       = (dbl % PW'(3)) != '0;
                end
                SLOT_16: bit_period = fsp1;
                default: bit_period = dbl;
            endcase
        end
    end

    assign mclk_period = PW'(div_q) + PW'(1);

    // Reject settings the dividers cannot produce as whole-cycle clocks.
    always_comb begin
        bad_cfg = 1'b0;
        if (host_q) begin
            if (frac || bit_period < PW'(2))
                bad_cfg = 1'b1;
            if (mclk_q && (mclk_period < PW'(2) || (bit_period % mclk_period) != '0))
                bad_cfg = 1'b1;
        end
    end

endmodule

// File: rtl/audclk_div.sv
// Module audclk_div: counts core cycles to make a clock of a given period.
// The output is high for ceil(P/2) cycles, then low; it restarts at the high
// phase whenever enabled. Assumes period >= 2 and constant while en is high.
module audclk_div #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] period,
    output logic          clk_out,
    output logic          fall
);

    logic [PW-1:0] cnt;
    logic [PW-1:0] hi;

    assign hi   = PW'(({1'b0, period} + (PW+1)'(1)) >> 1);
    assign fall = en && (cnt == hi);

    // Step the phase counter and register the clock level for this phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt     <= '0;
            clk_out <= 1'b0;
        end else begin
            clk_out <= (cnt < hi);
            cnt     <= (cnt == period - PW'(1)) ? '0 : cnt + PW'(1);
        end
    end

    assert_off_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !clk_out);

    assert_cnt_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < period));

endmodule

// File: rtl/audclk_wsseq.sv
// Module audclk_wsseq: counts bit-clock falling edges and produces word select
// and the slot and frame strobes. Word select changes with the falling edge
// that starts the last bit of a slot. Assumes slot length of 8 to 32.
module audclk_wsseq
    import audclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fall,
    input  logic [SLOT_W-1:0] slot_len,
    output logic              ws,
    output logic              slot_stb,
    output logic              frame_stb
);

    logic [SLOT_W:0] bcnt;
    logic            mid_edge;
    logic            end_edge;

    assign mid_edge = (bcnt == {1'b0, slot_len} - (SLOT_W+1)'(1));
    assign end_edge = (bcnt == {slot_len, 1'b0} - (SLOT_W+1)'(1));

    // Advance the frame position on each falling edge and toggle word select.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            bcnt      <= '0;
            ws        <= 1'b0;
            slot_stb  <= 1'b0;
            frame_stb <= 1'b0;
        end else begin
            slot_stb  <= 1'b0;
            frame_stb <= 1'b0;
            if (fall) begin
                if (end_edge) begin
                    bcnt      <= '0;
                    ws        <= 1'b0;
                    slot_stb  <= 1'b1;
                    frame_stb <= 1'b1;
                end else begin
                    bcnt <= bcnt + (SLOT_W+1)'(1);
                    if (mid_edge) begin
                        ws       <= 1'b1;
                        slot_stb <= 1'b1;
                    end
                end
            end
        end
    end

    assert_ws_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (ws != $past(ws))) |-> $past(fall));

    assert_frame_left_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> !ws);

    assert_frame_is_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> slot_stb);

endmodule

// File: rtl/audclk_csync.sv
// Module audclk_csync: brings an external bit clock and word select into the
// core clock domain through two flops, and derives slot and frame strobes
// from word-select changes. Assumes both inputs are much slower than clk.
module audclk_csync (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sck_pin,
    input  logic ws_pin,
    output logic sck_s,
    output logic ws_s,
    output logic slot_stb,
    output logic frame_stb
);

    logic sck_m;
    logic ws_m;
    logic ws_d;

    // Two-flop synchronizers plus one delayed word-select copy for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_m <= 1'b0;
            sck_s <= 1'b0;
            ws_m  <= 1'b0;
            ws_s  <= 1'b0;
            ws_d  <= 1'b0;
        end else begin
            sck_m <= sck_pin;
            sck_s <= sck_m;
            ws_m  <= ws_pin;
            ws_s  <= ws_m;
            ws_d  <= ws_s;
        end
    end

    assign slot_stb  = en && (ws_s != ws_d);
    assign frame_stb = en && ws_d && !ws_s;

endmodule

// File: rtl/audclk_gen.sv
// Module audclk_gen: audio serial port clock generator. In host role it
// drives master clock, bit clock and word select from the core clock; in
// client role it passes synchronized external clocks to the port. Assumes the
// configuration inputs are stable for two cycles before enable rises.
module audclk_gen
    import audclk_pkg::*;
#(
    parameter int FS_W  = 6,
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             host_mode,
    input  logic             mclk_on,
    input  logic             compact24,
    input  logic [2:0]       dlen,
    input  logic [FS_W-1:0]  fs_mult,
    input  logic [DIV_W-1:0] mclk_div,
    input  logic             sck_in,
    input  logic             ws_in,
    output logic             mck_o,
    output logic             sck_o,
    output logic             ws_o,
    output logic             pin_oe,
    output logic             sck_int,
    output logic             ws_int,
    output logic             frame_stb,
    output logic             slot_stb,
    output logic             cfg_err
);

    localparam int PW = (FS_W + 2 > DIV_W + 1) ? FS_W + 2 : DIV_W + 1;

    logic              run;
    logic              host_q;
    logic              mclk_q;
    logic [SLOT_W-1:0] slot_len;
    logic [PW-1:0]     bit_period;
    logic [PW-1:0]     mclk_period;
    logic              bad_cfg;
    logic              gen_en;
    logic              sck_fall;
    logic              mck_fall;
    logic              h_slot;
    logic              h_frame;
    logic              c_sck;
    logic              c_ws;
    logic              c_slot;
    logic              c_frame;

    // Register the enable so that the capture closes before the dividers start.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= enable;
    end

    audclk_cfg #(.FS_W(FS_W), .DIV_W(DIV_W), .PW(PW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .run        (run),
        .host_mode  (host_mode),
        .mclk_on    (mclk_on),
        .compact24  (compact24),
        .dlen       (dlen),
        .fs_mult    (fs_mult),
        .mclk_div   (mclk_div),
        .host_q     (host_q),
        .mclk_q     (mclk_q),
        .slot_len   (slot_len),
        .bit_period (bit_period),
        .mclk_period(mclk_period),
        .bad_cfg    (bad_cfg)
    );

    assign gen_en = run && host_q && !bad_cfg;

    audclk_div #(.PW(PW)) u_mclk_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (gen_en && mclk_q),
        .period (mclk_period),
        .clk_out(mck_o),
        .fall   (mck_fall)
    );

    audclk_div #(.PW(PW)) u_sck_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (gen_en),
        .period (bit_period),
        .clk_out(sck_o),
        .fall   (sck_fall)
    );

    audclk_wsseq u_ws (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (gen_en),
        .fall     (sck_fall),
        .slot_len (slot_len),
        .ws       (ws_o),
        .slot_stb (h_slot),
        .frame_stb(h_frame)
    );

    audclk_csync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run && !host_q),
        .sck_pin  (sck_in),
        .ws_pin   (ws_in),
        .sck_s    (c_sck),
        .ws_s     (c_ws),
        .slot_stb (c_slot),
        .frame_stb(c_frame)
    );

    assign pin_oe    = host_q;
    assign cfg_err   = run && bad_cfg;
    assign sck_int   = host_q ? sck_o   : c_sck;
    assign ws_int    = host_q ? ws_o    : c_ws;
    assign slot_stb  = host_q ? h_slot  : c_slot;
    assign frame_stb = host_q ? h_frame : c_frame;

    assert_quiet_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!mck_o && !sck_o && !ws_o));

    assert_client_no_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> (!mck_o && !sck_o && !ws_o));

    assert_mck_fall_from_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mck_fall |-> mck_o);

endmodule

// File: tb/audclk_gen_tb.sv
// Bench audclk_gen_tb: sweeps codes, flags, rate and divider values, comparing
// every enabled cycle against a waveform computed from the requirements.
module audclk_gen_tb;

    localparam int FS_W  = 6;
    localparam int DIV_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             host_mode = 1'b0;
    logic             mclk_on = 1'b0;
    logic             compact24 = 1'b0;
    logic [2:0]       dlen = '0;
    logic [FS_W-1:0]  fs_mult = '0;
    logic [DIV_W-1:0] mclk_div = '0;
    logic             sck_in = 1'b0;
    logic             ws_in = 1'b0;
    logic mck_o, sck_o, ws_o, pin_oe, sck_int, ws_int, frame_stb, slot_stb, cfg_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    audclk_gen #(.FS_W(FS_W), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .host_mode(host_mode),
        .mclk_on(mclk_on), .compact24(compact24), .dlen(dlen), .fs_mult(fs_mult),
        .mclk_div(mclk_div), .sck_in(sck_in), .ws_in(ws_in), .mck_o(mck_o),
        .sck_o(sck_o), .ws_o(ws_o), .pin_oe(pin_oe), .sck_int(sck_int),
        .ws_int(ws_int), .frame_stb(frame_stb), .slot_stb(slot_stb), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_slot(input int code, input int c24);
        if (code == 0) return 32;
        if (code <= 3) return (c24 != 0) ? 24 : 32;
        if (code <= 5) return 16;
        return 8;
    endfunction

    task automatic quiet_check(input string tag);
        chk({tag, " mck_o"}, mck_o, 0);
        chk({tag, " sck_o"}, sck_o, 0);
        chk({tag, " ws_o"}, ws_o, 0);
        chk({tag, " slot_stb"}, slot_stb, 0);
        chk({tag, " frame_stb"}, frame_stb, 0);
    endtask

    task automatic host_run(input int code, input int c24, input int mon, input int fs, input int dv);
        int s, pb, pm, hb, hm, n, falls;
        bit err, fall, sck_e, mck_e, ws_e, slot_e, frame_e;
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        quiet_check("R12 after disable");
        host_mode = 1'b1;
        mclk_on   = mon[0];
        compact24 = c24[0];
        dlen      = code[2:0];
        fs_mult   = FS_W'(fs);
        mclk_div  = DIV_W'(dv);
        @(negedge clk);
        @(negedge clk);
        s = exp_slot(code, c24);
        if (mon != 0) begin
            err = ((32 * (fs + 1)) % (2 * s)) != 0;
            pb  = (32 * (fs + 1)) / (2 * s);
            pm  = dv + 1;
            if (pb < 2 || pm < 2 || (pb % pm) != 0) err = 1'b1;
        end else begin
            pb  = fs + 1;
            pm  = 1;
            err = (pb < 2);
        end
        hb = (pb + 1) / 2;
        hm = (pm + 1) / 2;
        n  = err ? 24 : 2 * s * pb + pb + 8;
        falls = 0;
        enable = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (err) begin
                chk("R8 cfg_err set", cfg_err, 1);
                quiet_check("R8 silent on error");
            end else begin
                fall  = (k >= 1) && ((k - 1) % pb == hb);
                if (fall) falls++;
                sck_e   = (k >= 1) && ((k - 1) % pb < hb);
                mck_e   = (mon != 0) && (k >= 1) && ((k - 1) % pm < hm);
                ws_e    = (falls % (2 * s)) >= s;
                slot_e  = fall && (falls % s == 0);
                frame_e = fall && (falls % (2 * s) == 0);
                chk("R8 cfg_err clear", cfg_err, 0);
                chk("R1 pin_oe host", pin_oe, 1);
                chk("R1 sck_int follows pin", sck_int, sck_o);
                chk("R1 ws_int follows pin", ws_int, ws_o);
                if (mon != 0) chk("R4 R6 R9 sck_o", sck_o, sck_e);
                else          chk("R5 R6 R9 sck_o", sck_o, sck_e);
                if (mon != 0) chk("R4 R6 mck_o", mck_o, mck_e);
                else          chk("R5 mck_o off", mck_o, 0);
                chk("R3 R7 ws_o", ws_o, ws_e);
                chk("R11 slot_stb", slot_stb, slot_e);
                chk("R11 frame_stb", frame_stb, frame_e);
                if (k <= 1) begin
                    chk("R10 start phase sck", sck_o, (k == 1) ? 1 : 0);
                    chk("R10 start ws left", ws_o, 0);
                end
            end
            if (k == 3) begin
                fs_mult   = ~fs_mult;
                mclk_div  = ~mclk_div;
                dlen      = dlen ^ 3'd5;
                compact24 = ~compact24;
                mclk_on   = ~mclk_on;
                host_mode = 1'b0;
            end
        end
    endtask

    task automatic client_run();
        bit s1, s2, w1, w2, w3, sn, wn;
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        host_mode = 1'b0;
        mclk_on   = 1'b1;
        fs_mult   = '0;
        mclk_div  = '0;
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
        s1 = 0; s2 = 0; w1 = 0; w2 = 0; w3 = 0;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            if (n >= 4) begin
                chk("R2 sck_int latency", sck_int, s2);
                chk("R2 ws_int latency", ws_int, w2);
                chk("R2 slot_stb client", slot_stb, (w2 != w3) ? 1 : 0);
                chk("R2 frame_stb client", frame_stb, (w3 && !w2) ? 1 : 0);
                chk("R1 pin_oe client", pin_oe, 0);
                chk("R1 client pins quiet", mck_o | sck_o | ws_o, 0);
                chk("R8 no error in client", cfg_err, 0);
            end
            sn = ((n / 3) % 2) != 0;
            wn = ((n / 37) % 2) != 0;
            s2 = s1; s1 = sn;
            w3 = w2; w2 = w1; w1 = wn;
            sck_in = sn;
            ws_in  = wn;
        end
    endtask

    initial begin
        int fsl[7];
        fsl = '{0, 1, 2, 3, 5, 7, 11};
        repeat (3) @(negedge clk);
        quiet_check("R12 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        quiet_check("R12 after reset");
        chk("R8 no error after reset", cfg_err, 0);
        for (int code = 0; code < 8; code++)
            for (int c24 = 0; c24 < 2; c24++)
                for (int mon = 0; mon < 2; mon++)
                    for (int fi = 0; fi < 7; fi++)
                        for (int dv = 0; dv < ((mon != 0) ? 4 : 1); dv++)
                            host_run(code, c24, mon, fsl[fi], dv);
        client_run();
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        quiet_check("R12 final disable");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule